// File: doc/BRIEF.md
# Sixteen-Function Register ALU

This block is the execute stage for the two-register arithmetic and logic group of a compact 16-bit-instruction core. Each accepted cycle it takes a 4-bit function code, the current destination register value, a source register value and the four condition flags. One clock later it presents the 32-bit result, a destination write strobe and the new flag set. Register file access, fetch and decode sit outside the block. The caller forwards the result and flags and writes the register only when the strobe is high.

The function set holds bitwise operations, shifts and rotates whose amount comes from a register, add and subtract with the live carry, a reverse subtract from zero, a 32x32 multiply that keeps the low word, bit-clear and move-not. It also holds three compare-style functions that change only the flags. A decoder turns the code into a small group of strobes. A datapath carries out the operation and holds the registered output stage.

Top module: `alu16_core`

## Requirements
- R1: Function codes AND=0, XOR=1, OR=12, BIC=14 (dest AND NOT src) and MVN=15 (NOT src) give the stated bitwise result. N is result bit 31 and Z is set when the result is zero. C and V are passed through from flagsIn. flagsIn and flagsOut pack {N,Z,C,V} in bits [3:0], with N in bit 3.
- R2: Codes 2 (shift left), 3 (logical right), 4 (arithmetic right) and 7 (rotate right) shift the destination value by srcVal[7:0] and leave V unchanged. An amount of 0 returns the destination value unchanged and keeps C.
- R3: For shift left and logical right with amounts 1 to 32, C is the last bit shifted out. An amount of 32 gives result 0 with C equal to bit 0 (left) or bit 31 (right). Amounts above 32 give result 0 and C 0.
- R4: Arithmetic right with an amount of 32 or more fills the result with bit 31 and sets C to bit 31. Rotate right uses the amount modulo 32, and C becomes result bit 31. A non-zero multiple of 32 returns the value unchanged, with C set to bit 31.
- R5: Code 5 computes dest + src + C and code 6 computes dest + NOT src + C, where C is the incoming carry flag. C is the carry out of bit 31, which acts as NOT-borrow for subtraction. V is set on signed overflow.
- R6: Code 9 writes 0 + NOT src + 1, which is the two's-complement negation of the source, and sets N, Z, C and V as for an addition.
- R7: Code 8 (dest AND src), code 10 (dest + NOT src + 1) and code 11 (dest + src) update the flags as for their bitwise or arithmetic counterparts. They leave destWe low, while result still shows the computed value.
- R8: Code 13 returns the low 32 bits of dest times src, sets N and Z from that value, and keeps C and V.
- R9: outValid is high exactly one cycle after a cycle with inValid high. When inValid is low, outputs hold their last value and outValid is low. Reset clears outValid, destWe, result and flags to 0.
- R10: destWe is high in the output cycle of every code other than 8, 10 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present this cycle |
| opCode | input | 4 | Function code |
| dstVal | input | 32 | Destination register value (first operand) |
| srcVal | input | 32 | Source register value (second operand, shift amount) |
| flagsIn | input | 4 | Current {N,Z,C,V} |
| outValid | output | 1 | Result stage holds a new result |
| result | output | 32 | Computed value |
| destWe | output | 1 | Write result to destination register |
| flagsOut | output | 4 | Updated {N,Z,C,V} |

## Verification
The only state in the block is the output register, so any wrong decode or datapath value appears on the ports in the cycle right after the operation is accepted. A wrong strobe from the decoder shows up in one of three ways: a write strobe on a compare, a flag that should have passed through but changed, or a carry-in taken from the wrong source. Each of these shows at the next output. The shift corners at amounts 0, 31, 32, 33 and 64 and above, signed-overflow boundaries, and carry-in 0 and 1 are driven on purpose, because a random operand seldom reaches them.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  localparam int unsigned DataW  = 32;
  localparam int unsigned OpW    = 4;
  localparam int unsigned AmtW   = 8;
  localparam int unsigned FlagW  = 4;
  localparam int unsigned RotW   = $clog2(DataW);

  localparam int unsigned FlagN = 3;
  localparam int unsigned FlagZ = 2;
  localparam int unsigned FlagC = 1;
  localparam int unsigned FlagV = 0;

  typedef enum logic [3:0] {
    FN_AND, FN_XOR, FN_OR, FN_BIC, FN_MVN,
    FN_LSL, FN_LSR, FN_ASR, FN_ROR,
    FN_ADD, FN_MUL
  } fnSel_e;

  typedef enum logic [1:0] {
    CIN_ZERO, CIN_ONE, CIN_FLAG
  } cinSel_e;

  typedef struct packed {
    fnSel_e  fn;
    logic    zeroA;
    logic    invB;
    cinSel_e cin;
    logic    wrDest;
  } aluCtrl_t;

endpackage

// File: rtl/alu16_ctrl.sv
module alu16_ctrl
  import alu16_pkg::*;
(
  input  logic [OpW-1:0] opCode,
  output aluCtrl_t       ctrl
);

  always_comb begin
    ctrl.fn     = FN_AND;
    ctrl.zeroA  = 1'b0;
    ctrl.invB   = 1'b0;
    ctrl.cin    = CIN_ZERO;
    ctrl.wrDest = 1'b1;
    unique case (opCode)
      4'd0:  ctrl.fn = FN_AND;
      4'd1:  ctrl.fn = FN_XOR;
      4'd2:  ctrl.fn = FN_LSL;
      4'd3:  ctrl.fn = FN_LSR;
      4'd4:  ctrl.fn = FN_ASR;
      4'd5: begin
        ctrl.fn  = FN_ADD;
        ctrl.cin = CIN_FLAG;
      end
      4'd6: begin
        ctrl.fn   = FN_ADD;
        ctrl.invB = 1'b1;
        ctrl.cin  = CIN_FLAG;
      end
      4'd7:  ctrl.fn = FN_ROR;
      4'd8: begin
        ctrl.fn     = FN_AND;
        ctrl.wrDest = 1'b0;
      end
      4'd9: begin
        ctrl.fn    = FN_ADD;
        ctrl.zeroA = 1'b1;
        ctrl.invB  = 1'b1;
        ctrl.cin   = CIN_ONE;
      end
      4'd10: begin
        ctrl.fn     = FN_ADD;
        ctrl.invB   = 1'b1;
        ctrl.cin    = CIN_ONE;
        ctrl.wrDest = 1'b0;
      end
      4'd11: begin
        ctrl.fn     = FN_ADD;
        ctrl.cin    = CIN_ZERO;
        ctrl.wrDest = 1'b0;
      end
      4'd12: ctrl.fn = FN_OR;
      4'd13: ctrl.fn = FN_MUL;
      4'd14: ctrl.fn = FN_BIC;
      4'd15: ctrl.fn = FN_MVN;
      default: ctrl.fn = FN_AND;
    endcase
  end

endmodule

// File: rtl/alu16_dpath.sv
module alu16_dpath
  import alu16_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  aluCtrl_t           ctrl,
  input  logic [DataW-1:0]   dstVal,
  input  logic [DataW-1:0]   srcVal,
  input  logic [FlagW-1:0]   flagsIn,
  output logic               outValid,
  output logic [DataW-1:0]   result,
  output logic               destWe,
  output logic [FlagW-1:0]   flagsOut
);

  localparam int unsigned ExtW = DataW + 1;

  logic [DataW-1:0] opA, opB;
  logic             cinBit;
  logic [ExtW-1:0]  sumExt;
  logic [AmtW-1:0]  shAmt;
  logic [RotW-1:0]  rotAmt;
  logic [ExtW-1:0]  lslExt, lsrExt;
  logic signed [ExtW-1:0] asrExt;
  logic [2*DataW-1:0] rorExt;
  logic [DataW-1:0] prodLo;

  logic [DataW-1:0] nextRes;
  logic             nextC, nextV;
  logic             shZero;

  // adder operand shaping
  assign opA = ctrl.zeroA ? '0 : dstVal;
  assign opB = ctrl.invB ? ~srcVal : srcVal;

  always_comb begin
    unique case (ctrl.cin)
      CIN_ONE:  cinBit = 1'b1;
      CIN_FLAG: cinBit = flagsIn[FlagC];
      default:  cinBit = 1'b0;
    endcase
  end

  assign sumExt = {1'b0, opA} + {1'b0, opB} + {{DataW{1'b0}}, cinBit};

  // shifters: one guard bit catches the last bit moved out
  assign shAmt  = srcVal[AmtW-1:0];
  assign rotAmt = srcVal[RotW-1:0];
  assign shZero = (shAmt == '0);
  assign lslExt = {1'b0, dstVal} << shAmt;
  assign lsrExt = {dstVal, 1'b0} >> shAmt;
  assign asrExt = $signed({dstVal, 1'b0}) >>> shAmt;
  assign rorExt = {dstVal, dstVal} >> rotAmt;

  assign prodLo = dstVal * srcVal;

  always_comb begin
    nextRes = dstVal;
    nextC   = flagsIn[FlagC];
    nextV   = flagsIn[FlagV];
    unique case (ctrl.fn)
      FN_AND: nextRes = dstVal & srcVal;
      FN_XOR: nextRes = dstVal ^ srcVal;
      FN_OR:  nextRes = dstVal | srcVal;
      FN_BIC: nextRes = dstVal & ~srcVal;
      FN_MVN: nextRes = ~srcVal;
      FN_LSL: if (!shZero) begin
        nextRes = lslExt[DataW-1:0];
        nextC   = lslExt[DataW];
      end
      FN_LSR: if (!shZero) begin
        nextRes = lsrExt[DataW:1];
        nextC   = lsrExt[0];
      end
      FN_ASR: if (!shZero) begin
        nextRes = asrExt[DataW:1];
        nextC   = asrExt[0];
      end
      FN_ROR: if (!shZero) begin
        nextRes = rorExt[DataW-1:0];
        nextC   = rorExt[DataW-1];
      end
      FN_ADD: begin
        nextRes = sumExt[DataW-1:0];
        nextC   = sumExt[DataW];
        nextV   = (opA[DataW-1] == opB[DataW-1]) &&
                  (sumExt[DataW-1] != opA[DataW-1]);
      end
      FN_MUL: nextRes = prodLo;
      default: nextRes = dstVal;
    endcase
  end

  // registered result stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      destWe   <= 1'b0;
      flagsOut <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result          <= nextRes;
        destWe          <= ctrl.wrDest;
        flagsOut[FlagN] <= nextRes[DataW-1];
        flagsOut[FlagZ] <= (nextRes == '0);
        flagsOut[FlagC] <= nextC;
        flagsOut[FlagV] <= nextV;
      end
    end
  end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [3:0]       opCode,
  input  logic [31:0]      dstVal,
  input  logic [31:0]      srcVal,
  input  logic [3:0]       flagsIn,
  output logic             outValid,
  output logic [31:0]      result,
  output logic             destWe,
  output logic [3:0]       flagsOut
);

  aluCtrl_t ctrl;

  alu16_ctrl ctrl_i (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  alu16_dpath dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ctrl     (ctrl),
    .dstVal   (dstVal),
    .srcVal   (srcVal),
    .flagsIn  (flagsIn),
    .outValid (outValid),
    .result   (result),
    .destWe   (destWe),
    .flagsOut (flagsOut)
  );

endmodule

// File: rtl/alu16_core_chk.sv
module alu16_core_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [3:0]  opCode,
  input logic [31:0] dstVal,
  input logic [31:0] srcVal,
  input logic [3:0]  flagsIn,
  input logic        outValid,
  input logic [31:0] result,
  input logic        destWe,
  input logic [3:0]  flagsOut
);

  logic isFlagOnly, isBitwise, isShift, zeroAmt;
  assign isFlagOnly = (opCode == 4'd8) || (opCode == 4'd10) || (opCode == 4'd11);
  assign isBitwise  = (opCode == 4'd0) || (opCode == 4'd1) || (opCode == 4'd8) ||
                      (opCode == 4'd12) || (opCode == 4'd14) || (opCode == 4'd15);
  assign isShift    = (opCode == 4'd2) || (opCode == 4'd3) || (opCode == 4'd4) ||
                      (opCode == 4'd7);
  assign zeroAmt    = (srcVal[7:0] == 8'd0);

  assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_valid_drop_R9: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  assert_flag_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isFlagOnly) |=> !destWe);

  assert_writes_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !isFlagOnly) |=> destWe);

  assert_bitwise_keeps_cv_R1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isBitwise) |=> (flagsOut[1:0] == $past(flagsIn[1:0])));

  assert_zero_flag_R1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (flagsOut[2] == (result == 32'd0)));

  assert_shift_keeps_v_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isShift) |=> (flagsOut[0] == $past(flagsIn[0])));

  assert_zero_amount_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isShift && zeroAmt) |=>
      (result == $past(dstVal)) && (flagsOut[1] == $past(flagsIn[1])));

  assert_mul_keeps_cv_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode == 4'd13) |=> (flagsOut[1:0] == $past(flagsIn[1:0])));

endmodule

bind alu16_core alu16_core_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .opCode   (opCode),
  .dstVal   (dstVal),
  .srcVal   (srcVal),
  .flagsIn  (flagsIn),
  .outValid (outValid),
  .result   (result),
  .destWe   (destWe),
  .flagsOut (flagsOut)
);

// File: tb/alu16_core_tb_top.sv
`timescale 1ns/1ps
module alu16_core_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic [31:0] dstVal = '0;
  logic [31:0] srcVal = '0;
  logic [3:0]  flagsIn = '0;
  logic        outValid;
  logic [31:0] result;
  logic        destWe;
  logic [3:0]  flagsOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  alu16_core dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
    .dstVal(dstVal), .srcVal(srcVal), .flagsIn(flagsIn),
    .outValid(outValid), .result(result), .destWe(destWe), .flagsOut(flagsOut)
  );

  // behavioural reference, bit by bit
  task automatic refModel(input logic [3:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic [3:0] f,
                          output logic [31:0] res, output logic we,
                          output logic [3:0] fo);
    logic c, v;
    logic [31:0] x, y;
    logic ci;
    longint us, ss;
    int amt;
    bit arith;
    c = f[1]; v = f[0]; res = a; arith = 0; ci = 0; x = a; y = b;
    amt = int'(b[7:0]);
    we = !(op == 8 || op == 10 || op == 11);
    case (op)
      0, 8: res = a & b;
      1:    res = a ^ b;
      12:   res = a | b;
      14:   res = a & ~b;
      15:   res = ~b;
      13:   res = a * b;
      2: for (int i = 0; i < amt; i++) begin c = res[31]; res = res << 1; end
      3: for (int i = 0; i < amt; i++) begin c = res[0]; res = res >> 1; end
      4: for (int i = 0; i < amt; i++) begin c = res[0]; res = {res[31], res[31:1]}; end
      7: for (int i = 0; i < amt; i++) begin c = res[0]; res = {res[0], res[31:1]}; end
      5:  begin arith = 1; ci = f[1]; end
      6:  begin arith = 1; ci = f[1]; y = ~b; end
      9:  begin arith = 1; ci = 1; x = 0; y = ~b; end
      10: begin arith = 1; ci = 1; y = ~b; end
      11: begin arith = 1; ci = 0; end
      default: res = a;
    endcase
    if (arith) begin
      us = longint'({32'd0, x}) + longint'({32'd0, y}) + longint'(ci);
      ss = longint'($signed(x)) + longint'($signed(y)) + longint'(ci);
      res = us[31:0];
      c = us[32];
      v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
    end
    fo = {res[31], res == 32'd0, c, v};
  endtask

  task automatic check(input string tag, input logic [37:0] act, input logic [37:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got v=%b we=%b res=%h fl=%b, expected v=%b we=%b res=%h fl=%b",
               tag, act[37], act[36], act[35:4], act[3:0],
               exp[37], exp[36], exp[35:4], exp[3:0]);
    end
  endtask

  // drive at negedge, result registered at next posedge, compare at following negedge
  task automatic runOp(input string tag, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [3:0] f);
    logic [31:0] er; logic ew; logic [3:0] ef;
    refModel(op, a, b, f, er, ew, ef);
    inValid = 1; opCode = op; dstVal = a; srcVal = b; flagsIn = f;
    @(negedge clk);
    inValid = 0;
    check(tag, {outValid, destWe, result, flagsOut}, {1'b1, ew, er, ef});
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, got no completion, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] prevRes; logic prevWe; logic [3:0] prevFl;
    void'($urandom(32'd7187));
    repeat (3) @(negedge clk);
    check("R9 reset", {outValid, destWe, result, flagsOut}, 38'd0);
    rstN = 1;
    @(negedge clk);

    // R1 bitwise
    runOp("R1 and",  4'd0,  32'hF0F0_1234, 32'h0FF0_FF00, 4'b0011);
    runOp("R1 xor",  4'd1,  32'hAAAA_5555, 32'hAAAA_5555, 4'b0010);
    runOp("R1 or",   4'd12, 32'h8000_0000, 32'h0000_0001, 4'b0001);
    runOp("R1 bic",  4'd14, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 4'b0000);
    runOp("R1 mvn",  4'd15, 32'h1234_5678, 32'hFFFF_FFFF, 4'b1110);
    // R2 zero amount, amount taken from low byte
    runOp("R2 lsl0", 4'd2, 32'h8000_0001, 32'hFFFF_FF00, 4'b0010);
    runOp("R2 lsr0", 4'd3, 32'h8000_0001, 32'h0000_0100, 4'b0001);
    runOp("R2 asr0", 4'd4, 32'h8000_0001, 32'h0000_0000, 4'b0000);
    runOp("R2 ror0", 4'd7, 32'h8000_0001, 32'h1234_5600, 4'b0010);
    runOp("R2 lsl4", 4'd2, 32'h1800_0001, 32'h0000_0004, 4'b0000);
    // R3 logical shift edges
    runOp("R3 lsl31", 4'd2, 32'h0000_0003, 32'd31, 4'b0000);
    runOp("R3 lsl32", 4'd2, 32'h0000_0001, 32'd32, 4'b0000);
    runOp("R3 lsl33", 4'd2, 32'hFFFF_FFFF, 32'd33, 4'b0010);
    runOp("R3 lsr32", 4'd3, 32'h8000_0000, 32'd32, 4'b0000);
    runOp("R3 lsr33", 4'd3, 32'hFFFF_FFFF, 32'd33, 4'b0010);
    runOp("R3 lsr255", 4'd3, 32'hFFFF_FFFF, 32'd255, 4'b0010);
    // R4 arithmetic shift and rotate
    runOp("R4 asr32", 4'd4, 32'h8000_0000, 32'd32, 4'b0000);
    runOp("R4 asr200", 4'd4, 32'h7FFF_FFFF, 32'd200, 4'b0010);
    runOp("R4 asr1", 4'd4, 32'h8000_0003, 32'd1, 4'b0000);
    runOp("R4 ror32", 4'd7, 32'h8000_0000, 32'd32, 4'b0000);
    runOp("R4 ror64", 4'd7, 32'h0000_0001, 32'd64, 4'b0010);
    runOp("R4 ror36", 4'd7, 32'h0000_0018, 32'd36, 4'b0000);
    // R5 add/subtract with carry
    runOp("R5 adc ovf", 4'd5, 32'h7FFF_FFFF, 32'h0000_0000, 4'b0010);
    runOp("R5 adc wrap", 4'd5, 32'hFFFF_FFFF, 32'h0000_0001, 4'b0000);
    runOp("R5 sbc c1", 4'd6, 32'd5, 32'd5, 4'b0010);
    runOp("R5 sbc c0", 4'd6, 32'd5, 32'd5, 4'b0000);
    runOp("R5 sbc ovf", 4'd6, 32'h8000_0000, 32'd1, 4'b0010);
    // R6 negate
    runOp("R6 neg0", 4'd9, 32'h1234_5678, 32'd0, 4'b0000);
    runOp("R6 negmin", 4'd9, 32'd0, 32'h8000_0000, 4'b0000);
    runOp("R6 neg1", 4'd9, 32'd0, 32'd1, 4'b0010);
    // R7 flag-only
    runOp("R7 tst", 4'd8, 32'hF000_0000, 32'h0F00_0000, 4'b0011);
    runOp("R7 cmp eq", 4'd10, 32'd42, 32'd42, 4'b0000);
    runOp("R7 cmp lt", 4'd10, 32'd1, 32'd2, 4'b0010);
    runOp("R7 cmn", 4'd11, 32'hFFFF_FFFF, 32'd1, 4'b0001);
    // R8 multiply
    runOp("R8 mul", 4'd13, 32'h0001_0001, 32'h0001_0001, 4'b0011);
    runOp("R8 mul0", 4'd13, 32'h0001_0000, 32'h0001_0000, 4'b0001);
    runOp("R8 mulneg", 4'd13, 32'hFFFF_FFFF, 32'd3, 4'b0010);

    // R9 idle cycle holds outputs, drops valid
    prevRes = result; prevWe = destWe; prevFl = flagsOut;
    opCode = 4'd1; dstVal = 32'hDEAD_BEEF; srcVal = 32'h1; inValid = 0;
    @(negedge clk);
    check("R9 idle", {outValid, destWe, result, flagsOut}, {1'b0, prevWe, prevRes, prevFl});

    // R10 and all codes: random sweep
    for (int k = 0; k < 1600; k++) begin
      logic [31:0] ra, rb;
      ra = $urandom; rb = $urandom;
      if (k % 4 == 0) rb = rb & 32'h3F;
      runOp(((k % 16) inside {8, 10, 11}) ? "R7 sweep" : "R10 sweep",
            4'(k % 16), ra, rb, 4'($urandom));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule